// File: doc/BRIEF.md
# Sticky Reset Cause Recorder

This block keeps a record of why the system has been reset. Each reset source sends a one-cycle pulse. The pulse sets a dedicated flag bit in a register. That register lives in the always-on domain, so it keeps its contents through the ordinary resets it records. Flags from several resets build up over time. Software clears them only by writing ones to the bits it wants gone. A write of all ones empties the register.

The block also gives a decoded cause code, so firmware does not have to scan the bits itself. The decoder walks the sources from the lowest flag position upward, and the first set flag gives the code. When no flag is set, the code reports a hard reset. Only the power-on reset input clears the register without a software write.

There are eight sources, identified by their index on the event vector:

| Index | Source |
|---|---|
| 0 | reset pin |
| 1 | watchdog |
| 2 | soft reset |
| 3 | CPU lock-up |
| 4 | wake from system-off by GPIO detect |
| 5 | wake from system-off by low-power comparator |
| 6 | wake from system-off by debug interface |
| 7 | wake from system-off by NFC field detect |

The block has no state machine. Its only state is the flag register, and it has no named transitions.

Top module: `rstcause_rec`

## Requirements
- R1: A pulse on `src_evt[i]` sets the flag at bit position i for i in 0..3 and at bit position i+12 for i in 4..7. So pin is bit 0, watchdog bit 1, soft bit 2, lock-up bit 3, GPIO wake bit 16, comparator wake bit 17, debug wake bit 18 and NFC wake bit 19. The flag is visible on `flags_q` after the next rising clock edge.
- R2: A new event ORs its flag into the flags already held and never removes another flag.
- R3: Flags stay set across any number of cycles and later source events until software clears them.
- R4: A cycle with `wr_en` high clears every flag whose bit in `wr_data` is one. Flags whose write bit is zero are unchanged, and a write of all zeros changes nothing.
- R5: A write of 0xFFFFFFFF clears all flags.
- R6: When a source event and a clear of the same bit arrive in the same cycle, the flag ends up set.
- R7: `cause_code` gives the index (0..7) of the lowest-indexed source whose flag is set. Lower indices have priority.
- R8: `cause_code` is 8, meaning hard reset, whenever no flag is set.
- R9: While `por_n` is low, `flags_q` is zero at once, without waiting for a clock edge, and source events are ignored.
- R10: Bits other than 0–3 and 16–19 always read zero, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on domain clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous; clears all flags |
| src_evt | input | 8 | One-cycle pulse per reset source, indexed as in the table above |
| wr_en | input | 1 | Software write strobe |
| wr_data | input | 32 | Write data; each one clears the matching flag |
| flags_q | output | 32 | Current sticky flags |
| cause_code | output | 4 | Decoded cause: 0..7 source index, 8 = hard reset |

## Verification
The bound checker watches several rules on every clock edge:
- every event lands in its flag;
- flags never drop without a write;
- written-one bits are cleared unless an event sets them in the same cycle;
- the unused bits stay zero;
- the code always points at a set flag with no lower-priority-index flag set below it, or at hard reset when the register is empty.

Some behaviours only the bench's scenarios can show:
- the exact bit position each source index lands on;
- the full priority ranking as flags are removed one by one;
- the immediate, clockless clear under `por_n`;
- the persistence of flags after the power-on reset is released.

// File: rtl/rstcause_pkg.sv
package rstcause_pkg;

    localparam int RC_REG_W = 32;
    localparam int RC_SRC_N = 8;

    // Bit position of each source flag; software decodes this layout.
    function automatic int src_pos(input int idx);
        return (idx < 4) ? idx : idx + 12;
    endfunction

    // Mask of all bits that hold a flag.
    function automatic logic [RC_REG_W-1:0] flag_mask(input int nsrc);
        logic [RC_REG_W-1:0] m;
        m = '0;
        for (int i = 0; i < nsrc; i++) begin
            m[src_pos(i)] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/rstcause_map.sv
module rstcause_map
    import rstcause_pkg::*;
#(
    parameter int REG_W = RC_REG_W,
    parameter int SRC_N = RC_SRC_N
) (
    input  logic [SRC_N-1:0] src_evt,
    output logic [REG_W-1:0] set_mask
);

    logic [REG_W-1:0] part [SRC_N];

    // One shifted flag per source lane.
    for (genvar i = 0; i < SRC_N; i++) begin : g_src
        localparam logic [REG_W-1:0] LANE_BIT = REG_W'(1) << src_pos(i);
        assign part[i] = src_evt[i] ? LANE_BIT : '0;
    end

    always_comb begin
        set_mask = '0;
        for (int i = 0; i < SRC_N; i++) begin
            set_mask = set_mask | part[i];
        end
    end

endmodule

// File: rtl/rstcause_store.sv
module rstcause_store
    import rstcause_pkg::*;
#(
    parameter int REG_W = RC_REG_W,
    parameter int SRC_N = RC_SRC_N
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic [REG_W-1:0] set_mask,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] flags_q
);

    localparam logic [REG_W-1:0] VALID = flag_mask(SRC_N);

    logic [REG_W-1:0] clr_mask;
    logic [REG_W-1:0] flags_d;

    always_comb begin
        clr_mask = wr_en ? wr_data : '0;
        // Clear first, then set: an event wins over a same-cycle clear.
        flags_d  = ((flags_q & ~clr_mask) | set_mask) & VALID;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            flags_q <= '0;
        end else begin
            flags_q <= flags_d;
        end
    end

endmodule

// File: rtl/rstcause_prio.sv
module rstcause_prio
    import rstcause_pkg::*;
#(
    parameter int REG_W  = RC_REG_W,
    parameter int SRC_N  = RC_SRC_N,
    parameter int CODE_W = $clog2(SRC_N + 1)
) (
    input  logic [REG_W-1:0]  flags,
    output logic [CODE_W-1:0] code
);

    localparam logic [CODE_W-1:0] HARD_CODE = CODE_W'(SRC_N);

    // Scan from the top down so the lowest set index overwrites last.
    always_comb begin
        code = HARD_CODE;
        for (int i = SRC_N - 1; i >= 0; i--) begin
            if (flags[src_pos(i)]) begin
                code = CODE_W'(i);
            end
        end
    end

endmodule

// File: rtl/rstcause_rec.sv
module rstcause_rec
    import rstcause_pkg::*;
#(
    parameter int REG_W  = RC_REG_W,
    parameter int SRC_N  = RC_SRC_N,
    parameter int CODE_W = $clog2(SRC_N + 1)
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic [SRC_N-1:0]  src_evt,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wr_data,
    output logic [REG_W-1:0]  flags_q,
    output logic [CODE_W-1:0] cause_code
);

    logic [REG_W-1:0] set_mask;

    rstcause_map #(.REG_W(REG_W), .SRC_N(SRC_N)) u_map (
        .src_evt  (src_evt),
        .set_mask (set_mask)
    );

    rstcause_store #(.REG_W(REG_W), .SRC_N(SRC_N)) u_store (
        .clk      (clk),
        .por_n    (por_n),
        .set_mask (set_mask),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .flags_q  (flags_q)
    );

    rstcause_prio #(.REG_W(REG_W), .SRC_N(SRC_N), .CODE_W(CODE_W)) u_prio (
        .flags (flags_q),
        .code  (cause_code)
    );

endmodule

// File: rtl/rstcause_rec_chk.sv
module rstcause_rec_chk
    import rstcause_pkg::*;
#(
    parameter int REG_W  = RC_REG_W,
    parameter int SRC_N  = RC_SRC_N,
    parameter int CODE_W = $clog2(SRC_N + 1)
) (
    input logic              clk,
    input logic              por_n,
    input logic [SRC_N-1:0]  src_evt,
    input logic              wr_en,
    input logic [REG_W-1:0]  wr_data,
    input logic [REG_W-1:0]  flags_q,
    input logic [CODE_W-1:0] cause_code
);

    logic [REG_W-1:0] evt_bits;
    logic [REG_W-1:0] used_bits;
    logic [REG_W-1:0] below_code;
    logic             code_flag;

    always_comb begin
        evt_bits   = '0;
        used_bits  = '0;
        below_code = '0;
        code_flag  = 1'b0;
        for (int i = 0; i < SRC_N; i++) begin
            used_bits[src_pos(i)] = 1'b1;
            if (src_evt[i]) evt_bits[src_pos(i)] = 1'b1;
            if (i < int'(cause_code)) below_code[src_pos(i)] = 1'b1;
            if (i == int'(cause_code)) code_flag = flags_q[src_pos(i)];
        end
    end

    // R1 R6
    evt_lands_chk: assert property (@(posedge clk) disable iff (!por_n)
        (|evt_bits) |=> ((flags_q & $past(evt_bits)) == $past(evt_bits)));

    // R2 R3
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
        !wr_en |=> ((flags_q & $past(flags_q)) == $past(flags_q)));

    // R4
    w1c_clear_chk: assert property (@(posedge clk) disable iff (!por_n)
        wr_en |=> ((flags_q & $past(wr_data) & ~$past(evt_bits)) == '0));

    // R10
    unused_zero_chk: assert property (@(posedge clk) disable iff (!por_n)
        ((flags_q & ~used_bits) == '0));

    // R8
    hard_code_chk: assert property (@(posedge clk) disable iff (!por_n)
        (flags_q == '0) |-> (cause_code == CODE_W'(SRC_N)));

    // R7
    prio_code_chk: assert property (@(posedge clk) disable iff (!por_n)
        (int'(cause_code) < SRC_N) |-> (code_flag && ((flags_q & below_code) == '0)));

endmodule

bind rstcause_rec rstcause_rec_chk #(.REG_W(REG_W), .SRC_N(SRC_N), .CODE_W(CODE_W)) u_chk (
    .clk        (clk),
    .por_n      (por_n),
    .src_evt    (src_evt),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .flags_q    (flags_q),
    .cause_code (cause_code)
);

// File: tb/rstcause_rec_bench.sv
`timescale 1ns/1ps
module rstcause_rec_bench;

    logic        clk = 1'b0;
    logic        por_n;
    logic [7:0]  src_evt;
    logic        wr_en;
    logic [31:0] wr_data;
    logic [31:0] flags_q;
    logic [3:0]  cause_code;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    rstcause_rec u_rstcause_rec (
        .clk        (clk),
        .por_n      (por_n),
        .src_evt    (src_evt),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .flags_q    (flags_q),
        .cause_code (cause_code)
    );

    // {evt[7:0], wr_en, wr_data[31:0], exp_flags[31:0], exp_code[3:0]}
    localparam int NROW = 19;
    localparam logic [76:0] TBL [0:NROW-1] = '{
        {8'h02, 1'b0, 32'h0000_0000, 32'h0000_0002, 4'd1}, // R1 watchdog
        {8'h80, 1'b0, 32'h0000_0000, 32'h0008_0002, 4'd1}, // R2 NFC ORs in
        {8'h00, 1'b0, 32'h0000_0000, 32'h0008_0002, 4'd1}, // R3 hold
        {8'h00, 1'b1, 32'h0000_0002, 32'h0008_0000, 4'd7}, // R4 clear one
        {8'h10, 1'b0, 32'h0000_0000, 32'h0009_0000, 4'd4}, // R7 GPIO wake
        {8'h01, 1'b0, 32'h0000_0000, 32'h0009_0001, 4'd0}, // R7 pin wins
        {8'h00, 1'b1, 32'h0001_0001, 32'h0008_0000, 4'd7}, // R4 two bits
        {8'h24, 1'b0, 32'h0000_0000, 32'h000A_0004, 4'd2}, // R1 two sources
        {8'h08, 1'b1, 32'h0000_0008, 32'h000A_000C, 4'd2}, // R6 set beats clear
        {8'h00, 1'b1, 32'h0000_0000, 32'h000A_000C, 4'd2}, // R4 zero write
        {8'h40, 1'b0, 32'h0000_0000, 32'h000E_000C, 4'd2}, // R2 debug wake
        {8'h00, 1'b1, 32'h0000_0004, 32'h000E_0008, 4'd3}, // R7 lock-up next
        {8'h00, 1'b1, 32'h0000_0008, 32'h000E_0000, 4'd5}, // R7 comparator
        {8'h00, 1'b1, 32'h0002_0000, 32'h000C_0000, 4'd6}, // R7 debug
        {8'h02, 1'b1, 32'hFFFF_FFFF, 32'h0000_0002, 4'd1}, // R6 R5
        {8'h00, 1'b1, 32'hFFFF_FFFF, 32'h0000_0000, 4'd8}, // R5 R8
        {8'hFF, 1'b0, 32'h0000_0000, 32'h000F_000F, 4'd0}, // R1 all
        {8'h00, 1'b1, 32'hFFF0_FFF0, 32'h000F_000F, 4'd0}, // R10 unused write
        {8'h00, 1'b1, 32'hFFFF_FFFF, 32'h0000_0000, 4'd8}  // R5 R8
    };

    function automatic int pos_of(input int i);
        return (i < 4) ? i : i + 12;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R3 actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        por_n   = 1'b0;
        src_evt = '0;
        wr_en   = 1'b0;
        wr_data = '0;
        repeat (3) @(negedge clk);
        check("R9 reset flags", flags_q, 32'h0);
        check("R8 reset code", {28'h0, cause_code}, 32'd8);
        por_n = 1'b1;

        for (int r = 0; r < NROW; r++) begin
            {src_evt, wr_en, wr_data} = TBL[r][76:36];
            @(negedge clk);
            check($sformatf("R1 R2 R4 R6 R10 row %0d flags", r), flags_q, TBL[r][35:4]);
            check($sformatf("R7 R8 row %0d code", r), {28'h0, cause_code}, {28'h0, TBL[r][3:0]});
        end

        // Each source alone: position and code (R1 R7).
        for (int i = 0; i < 8; i++) begin
            src_evt = 8'(1 << i);
            wr_en   = 1'b0;
            @(negedge clk);
            check("R1 single source bit", flags_q, 32'h1 << pos_of(i));
            check("R7 single source code", {28'h0, cause_code}, i);
            src_evt = '0;
            wr_en   = 1'b1;
            wr_data = 32'hFFFF_FFFF;
            @(negedge clk);
            check("R5 clear after single", flags_q, 32'h0);
        end
        wr_en = 1'b0;

        // Power-on reset clears without a clock edge (R9).
        src_evt = 8'hFF;
        @(negedge clk);
        check("R9 pre-reset flags", flags_q, 32'h000F_000F);
        #2 por_n = 1'b0;
        #1 check("R9 async clear", flags_q, 32'h0);
        @(negedge clk);
        check("R9 events ignored in reset", flags_q, 32'h0);
        check("R8 code in reset", {28'h0, cause_code}, 32'd8);
        src_evt = '0;
        por_n   = 1'b1;
        @(negedge clk);
        check("R9 after release", flags_q, 32'h0);

        // Long hold without writes (R3).
        src_evt = 8'h08;
        @(negedge clk);
        src_evt = '0;
        repeat (20) @(negedge clk);
        check("R3 long hold", flags_q, 32'h0000_0008);
        check("R7 hold code", {28'h0, cause_code}, 32'd3);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule